// File: doc/BRIEF.md
# DDR Read Data-Valid Timer

This block sits on the controller side of a registered DDR memory interface. It keeps the burst and latency settings that software loads into the memory's base mode register. For every READ it issues, it predicts the exact half-clock slots in which read data will arrive. The physical strobe capture logic can then use these slots as a data-valid window. Each slot comes with a beat index, so the capture path knows which word of the burst is on the bus.

The block runs on a clock at twice the memory clock rate. The input `ck_edge` is high on the fast cycles that line up with a memory clock rising edge, and commands are taken only on those cycles. A mode-register-set command is decoded from the address and bank inputs. Reserved codes are refused, and the last good settings are kept. When the module buffers its command and address lines in a register stage, one whole memory clock (two half-clock slots) is added to the programmed latency.

The command input and the valid window have no valid/ready handshake. The DRAM cannot stall, so neither side has back-pressure: a command presented on an edge cycle is taken at once, and every window runs to the end with no way to hold it.

Top module: `ddr_rd_timer`

## Requirements
- R1: A synchronous active-low reset clears `cfg_ok`, `cfg_err`, `rd_valid` and `rd_err` to 0, starting from the first clock edge that samples `rst_n` low.
- R2: An MRS command (`cmd_op`=1) with `bank`=0 and legal codes loads the settings, which are visible after the registering edge:
  - `burst_len` becomes 2, 4 or 8 for `addr[2:0]` = 1, 2 or 3.
  - `burst_interleaved` becomes `addr[3]`.
  - `cfg_ok` becomes 1 and `cfg_err` becomes 0.
- R3: An MRS with a nonzero `bank` changes none of the settings and leaves `cfg_err` unchanged.
- R4: An MRS with `bank`=0 is refused if any of these holds:
  - `addr[2:0]` is outside 1..3;
  - `addr[6:4]` is neither 2 nor 6;
  - `addr[12:7]` is neither 0 nor 2.

  A refused MRS keeps the previous settings and sets `cfg_err`. The flag stays set until a legal load clears it.
- R5: `lat_hc` gives the effective read latency in half-clock slots. It is 4 for `addr[6:4]`=2 and 5 for `addr[6:4]`=6, plus 2 while `registered_mode` is 1.
- R6: A READ (`cmd_op`=2) registered at edge P0 while `cfg_ok` is 1 makes `rd_valid` high from edge P0+`lat_hc` for `burst_len` consecutive fast cycles. `rd_beat` counts 0 to `burst_len`-1 across these cycles, and `rd_last` marks the final one.
- R7: READs spaced exactly `burst_len`/2 memory clocks apart give windows that touch with no gap, and the beat index restarts at 0 for each one.
- R8: A READ registered while `cfg_ok` is 0 makes `rd_err` high for exactly the following cycle and produces no window.
- R9: A command presented on a cycle with `ck_edge` low has no effect: the settings stay the same and no window or error follows.
- R10: Reset cancels any window still pending or running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the memory clock rate |
| rst_n | input | 1 | Synchronous reset, active low |
| ck_edge | input | 1 | High on fast cycles aligned to a memory clock rising edge |
| registered_mode | input | 1 | Module has a command/address register stage (adds one clock of latency) |
| cmd_valid | input | 1 | A command is present |
| cmd_op | input | 2 | 0 idle, 1 mode register set, 2 read, 3 ignored |
| addr | input | ADDR_W | Address bus; carries the mode word for MRS |
| bank | input | BANK_W | Bank address; must be 0 to target the base mode register |
| cfg_ok | output | 1 | A legal mode word has been loaded since reset |
| cfg_err | output | 1 | Sticky flag set by a refused mode word |
| burst_len | output | 4 | Current burst length in beats (0 when unprogrammed) |
| burst_interleaved | output | 1 | Current burst type, 1 for interleaved |
| lat_hc | output | LAT_W | Effective read latency in half-clock slots |
| rd_valid | output | 1 | Read data expected in this half-clock slot |
| rd_beat | output | BEAT_W | Beat index within the current burst |
| rd_last | output | 1 | Final beat of the current burst |
| rd_err | output | 1 | One-cycle pulse: READ issued without legal settings |

## Verification
Mode settings and `rd_err` are due one fast cycle after the edge that registers the command. The bench checks them at the falling edge right after that registering edge. Each window starts exactly `lat_hc` fast cycles after the registering edge and lasts `burst_len` cycles. The bench computes these slots from its own model of the settings, writes the expected valid, beat and last values into a table indexed by cycle number, and a monitor compares every cycle against that table at the falling edge. Reset and ignored commands clear or skip table entries, so a stray or leftover window shows up as a mismatch in the exact cycle where it appears.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;

  localparam int LEN_W = 4;
  localparam int HC_W  = 3;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_MRS  = 2'd1,
    OP_READ = 2'd2,
    OP_SPARE = 2'd3
  } cmd_op_e;

  // Burst length field -> beats; 0 flags a reserved code.
  function automatic logic [LEN_W-1:0] beats_of(input logic [2:0] code);
    case (code)
      3'd1:    beats_of = LEN_W'(2);
      3'd2:    beats_of = LEN_W'(4);
      3'd3:    beats_of = LEN_W'(8);
      default: beats_of = '0;
    endcase
  endfunction

  // Latency field -> half-clock slots; 0 flags a reserved code.
  function automatic logic [HC_W-1:0] slots_of(input logic [2:0] code);
    case (code)
      3'd2:    slots_of = HC_W'(4);
      3'd6:    slots_of = HC_W'(5);
      default: slots_of = '0;
    endcase
  endfunction

  // Operating-mode field: plain, or plain with DLL reset.
  function automatic logic opmode_legal(input logic [5:0] f);
    opmode_legal = (f == 6'd0) || (f == 6'd2);
  endfunction

endpackage

// File: rtl/ddr_mode_reg.sv
module ddr_mode_reg
  import ddr_rd_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_stb,
  input  logic [ADDR_W-1:0] word,
  input  logic [BANK_W-1:0] sel,
  output logic [LEN_W-1:0]  beats,
  output logic              interleave,
  output logic [HC_W-1:0]   cl_slots,
  output logic              loaded,
  output logic              refused
);

  logic [LEN_W-1:0] dec_beats;
  logic [HC_W-1:0]  dec_slots;
  logic             word_legal;
  logic             targets_base;

  always_comb begin
    dec_beats    = beats_of(word[2:0]);
    dec_slots    = slots_of(word[6:4]);
    word_legal   = (dec_beats != '0) && (dec_slots != '0) && opmode_legal(word[12:7]);
    targets_base = (sel == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beats      <= '0;
      interleave <= 1'b0;
      cl_slots   <= '0;
      loaded     <= 1'b0;
      refused    <= 1'b0;
    end else if (load_stb && targets_base) begin
      if (word_legal) begin
        beats      <= dec_beats;
        interleave <= word[3];
        cl_slots   <= dec_slots;
        loaded     <= 1'b1;
        refused    <= 1'b0;
      end else begin
        refused    <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ddr_lat_pipe.sv
module ddr_lat_pipe #(
  parameter int DEPTH = 8,
  localparam int LAT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [LAT_W-1:0] delay,
  output logic             fire
);

  logic [DEPTH-1:0] slot_q;

  // A launch enters at stage delay-1; stage 0 fires one cycle before the
  // window edge so the burst generator's register lands on edge P0+delay.
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic from_up;
    if (i == DEPTH - 1) begin : g_top
      assign from_up = 1'b0;
    end else begin : g_mid
      assign from_up = slot_q[i+1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) slot_q[i] <= 1'b0;
      else        slot_q[i] <= from_up | (launch && (delay == LAT_W'(i + 1)));
    end
  end

  assign fire = slot_q[0];

endmodule

// File: rtl/ddr_burst_gen.sv
module ddr_burst_gen
  import ddr_rd_pkg::*;
#(
  parameter int MAX_BL = 8,
  localparam int BEAT_W = $clog2(MAX_BL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  beats,
  output logic              active,
  output logic [BEAT_W-1:0] beat,
  output logic              final_beat
);

  logic [LEN_W-1:0] len_q;
  logic             at_end;

  assign at_end     = ({{(LEN_W-BEAT_W){1'b0}}, beat} == len_q - LEN_W'(1));
  assign final_beat = active && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      beat   <= '0;
      len_q  <= '0;
    end else if (start) begin
      active <= 1'b1;
      beat   <= '0;
      len_q  <= beats;
    end else if (active) begin
      if (at_end) active <= 1'b0;
      else        beat   <= beat + BEAT_W'(1);
    end
  end

endmodule

// File: rtl/ddr_rd_timer.sv
module ddr_rd_timer
  import ddr_rd_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int BANK_W     = 2,
  parameter int MAX_BL     = 8,
  parameter int REG_HC     = 2,
  parameter int PIPE_DEPTH = 8,
  localparam int BEAT_W = $clog2(MAX_BL),
  localparam int LAT_W  = $clog2(PIPE_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ck_edge,
  input  logic              registered_mode,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank,
  output logic              cfg_ok,
  output logic              cfg_err,
  output logic [3:0]        burst_len,
  output logic              burst_interleaved,
  output logic [LAT_W-1:0]  lat_hc,
  output logic              rd_valid,
  output logic [BEAT_W-1:0] rd_beat,
  output logic              rd_last,
  output logic              rd_err
);

  logic            cmd_hit, mrs_stb, read_stb, launch, fire;
  logic [HC_W-1:0] cl_slots;

  assign cmd_hit  = cmd_valid && ck_edge;
  assign mrs_stb  = cmd_hit && (cmd_op == OP_MRS);
  assign read_stb = cmd_hit && (cmd_op == OP_READ);
  assign launch   = read_stb && cfg_ok;
  assign lat_hc   = LAT_W'(cl_slots) + (registered_mode ? LAT_W'(REG_HC) : LAT_W'(0));

  ddr_mode_reg #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .load_stb(mrs_stb), .word(addr), .sel(bank),
    .beats(burst_len), .interleave(burst_interleaved), .cl_slots(cl_slots),
    .loaded(cfg_ok), .refused(cfg_err)
  );

  ddr_lat_pipe #(.DEPTH(PIPE_DEPTH)) u_pipe (
    .clk(clk), .rst_n(rst_n), .launch(launch), .delay(lat_hc), .fire(fire)
  );

  ddr_burst_gen #(.MAX_BL(MAX_BL)) u_burst (
    .clk(clk), .rst_n(rst_n), .start(fire), .beats(burst_len),
    .active(rd_valid), .beat(rd_beat), .final_beat(rd_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rd_err <= 1'b0;
    else        rd_err <= read_stb && !cfg_ok;
  end

endmodule

// File: rtl/ddr_rd_timer_chk.sv
module ddr_rd_timer_chk #(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2,
  parameter int BEAT_W = 3,
  parameter int LAT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ck_edge,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [ADDR_W-1:0] addr,
  input logic [BANK_W-1:0] bank,
  input logic              cfg_ok,
  input logic              cfg_err,
  input logic [3:0]        burst_len,
  input logic              burst_interleaved,
  input logic              rd_valid,
  input logic [BEAT_W-1:0] rd_beat,
  input logic              rd_last,
  input logic              rd_err
);

  logic mrs_base, word_bad;
  assign mrs_base = ck_edge && cmd_valid && (cmd_op == 2'd1) && (bank == '0);
  assign word_bad = !(addr[2:0] inside {3'd1, 3'd2, 3'd3}) ||
                    !(addr[6:4] inside {3'd2, 3'd6}) ||
                    !(addr[12:7] inside {6'd0, 6'd2});

  p_good_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_base && !word_bad |=> cfg_ok && !cfg_err && burst_interleaved == $past(addr[3]));

  p_other_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ck_edge && cmd_valid && cmd_op == 2'd1 && bank != '0
    |=> $stable(burst_len) && $stable(burst_interleaved) && $stable(cfg_err) && $stable(cfg_ok));

  p_refused_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_base && word_bad |=> cfg_err && $stable(burst_len) && $stable(burst_interleaved));

  p_beat_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_last |=> rd_valid && (rd_beat == $past(rd_beat) + BEAT_W'(1) || rd_beat == '0));

  p_last_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);

  p_window_needs_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> cfg_ok);

  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> !cfg_ok && !rd_valid);

  p_off_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ck_edge |=> !rd_err && $stable(cfg_err) && $stable(burst_len));

endmodule

bind ddr_rd_timer ddr_rd_timer_chk #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .BEAT_W(BEAT_W), .LAT_W(LAT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ck_edge(ck_edge), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .addr(addr), .bank(bank), .cfg_ok(cfg_ok), .cfg_err(cfg_err),
  .burst_len(burst_len), .burst_interleaved(burst_interleaved),
  .rd_valid(rd_valid), .rd_beat(rd_beat), .rd_last(rd_last), .rd_err(rd_err)
);

// File: tb/ddr_rd_timer_tb_top.sv
module ddr_rd_timer_tb_top;
  localparam int CLK_P = 10;
  localparam int N     = 8192;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, ck_edge = 1'b0, registered_mode = 1'b0, cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [12:0] addr = '0;
  logic [1:0]  bank = '0;
  logic        cfg_ok, cfg_err, burst_interleaved, rd_valid, rd_last, rd_err;
  logic [3:0]  burst_len, lat_hc;
  logic [2:0]  rd_beat;

  always #(CLK_P/2) clk = ~clk;

  ddr_rd_timer dut_i (
    .clk(clk), .rst_n(rst_n), .ck_edge(ck_edge), .registered_mode(registered_mode),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .addr(addr), .bank(bank),
    .cfg_ok(cfg_ok), .cfg_err(cfg_err), .burst_len(burst_len),
    .burst_interleaved(burst_interleaved), .lat_hc(lat_hc), .rd_valid(rd_valid),
    .rd_beat(rd_beat), .rd_last(rd_last), .rd_err(rd_err)
  );

  int cyc_n = 0;
  always @(posedge clk) cyc_n <= cyc_n + 1;

  bit ev[N]; bit el[N]; bit ee[N]; int eb[N];
  int total = 0, bad = 0;
  bit mon_on = 0;

  // bench model of the mode settings
  bit m_ok = 0, m_err = 0, m_il = 0;
  int m_len = 0, m_cl = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d (cycle %0d)", tag, act, exp, cyc_n);
    end
  endtask

  // per-cycle window monitor (R6 R7 R8 R10)
  always @(negedge clk) begin
    if (mon_on && cyc_n < N) begin
      total++;
      if (rd_valid !== ev[cyc_n] || rd_err !== ee[cyc_n] ||
          (ev[cyc_n] && (int'(rd_beat) != eb[cyc_n] || rd_last !== el[cyc_n]))) begin
        bad++;
        $display("FAIL R6 R7 R8 R10 window cycle %0d act v=%0b b=%0d l=%0b e=%0b exp v=%0b b=%0d l=%0b e=%0b",
                 cyc_n, rd_valid, rd_beat, rd_last, rd_err, ev[cyc_n], eb[cyc_n], el[cyc_n], ee[cyc_n]);
      end
    end
  end

  function automatic int lat_model();
    return ((m_cl == 2) ? 4 : 5) + (registered_mode ? 2 : 0);
  endfunction

  // command on a memory-clock edge cycle, then one off-edge cycle
  task automatic cmd(input bit v, input logic [1:0] op, input logic [12:0] a, input logic [1:0] b);
    int p0, len;
    bit ok_bl, ok_cl, ok_op;
    @(negedge clk);
    ck_edge = 1; cmd_valid = v; cmd_op = op; addr = a; bank = b;
    p0 = cyc_n + 1;
    if (v && op == 2'd2) begin
      if (m_ok) begin
        for (int k = 0; k < m_len; k++) begin
          if (p0 + lat_model() + k < N) begin
            ev[p0 + lat_model() + k] = 1;
            eb[p0 + lat_model() + k] = k;
            el[p0 + lat_model() + k] = (k == m_len - 1);
          end
        end
      end else if (p0 < N) ee[p0] = 1;
    end
    if (v && op == 2'd1 && b == 2'd0) begin
      ok_bl = (a[2:0] >= 1 && a[2:0] <= 3);
      ok_cl = (a[6:4] == 2 || a[6:4] == 6);
      ok_op = (a[12:7] == 0 || a[12:7] == 2);
      len = 1 << a[2:0];
      if (ok_bl && ok_cl && ok_op) begin
        m_ok = 1; m_err = 0; m_len = len; m_il = a[3]; m_cl = a[6:4];
      end else m_err = 1;
    end
    @(negedge clk);
    ck_edge = 0; cmd_valid = 0;
  endtask

  // command on a cycle with ck_edge low (R9): model untouched
  task automatic skew_cmd(input logic [1:0] op, input logic [12:0] a);
    @(negedge clk);
    ck_edge = 0; cmd_valid = 1; cmd_op = op; addr = a; bank = 0;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cmd(0, 2'd0, 13'd0, 2'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cmd_valid = 0; ck_edge = 0;
    for (int i = cyc_n + 1; i < N; i++) begin ev[i] = 0; ee[i] = 0; end
    m_ok = 0; m_err = 0;
    @(negedge clk);
    chk("R1 cfg_ok", cfg_ok, 0); chk("R1 cfg_err", cfg_err, 0);
    chk("R1 rd_valid", rd_valid, 0); chk("R1 rd_err", rd_err, 0);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic chk_cfg(input string tag);
    chk({tag, " cfg_ok"}, cfg_ok, m_ok);
    chk({tag, " cfg_err"}, cfg_err, m_err);
    if (m_ok) begin
      chk({tag, " burst_len"}, burst_len, m_len);
      chk({tag, " interleave"}, burst_interleaved, m_il);
      chk("R5 lat_hc", lat_hc, lat_model());
    end
  endtask

  function automatic logic [12:0] mw(input int op6, input int cl, input int il, input int bl);
    return {6'(op6), 3'(cl), 1'(il), 3'(bl)};
  endfunction

  initial begin
    #(CLK_P * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cls[2];
    cls[0] = 2; cls[1] = 6;
    repeat (2) @(negedge clk);
    mon_on = 1;
    do_reset();

    // R8: read before any legal load
    cmd(1, 2'd2, 13'd0, 2'd0);
    idle(6);
    chk("R8 still unprogrammed", cfg_ok, 0);

    // R2 R4: sweep of every burst and latency code
    for (int bl = 0; bl < 8; bl++)
      for (int cl = 0; cl < 8; cl++) begin
        cmd(1, 2'd1, mw(0, cl, bl & 1, bl), 2'd0);
        chk_cfg((bl >= 1 && bl <= 3 && (cl == 2 || cl == 6)) ? "R2" : "R4");
      end
    // R4: operating-mode field patterns, then recovery by a legal load
    for (int op6 = 0; op6 < 64; op6 += 3) begin
      cmd(1, 2'd1, mw(op6, 6, 1, 2), 2'd0);
      chk_cfg((op6 == 0 || op6 == 2) ? "R2" : "R4");
    end
    cmd(1, 2'd1, mw(2, 2, 0, 3), 2'd0);
    chk_cfg("R2 dll reset word");

    // R3: other banks leave everything alone
    for (int b = 1; b < 4; b++) begin
      cmd(1, 2'd1, mw(0, 6, 1, 1), 2'(b));
      chk_cfg("R3");
      cmd(1, 2'd1, mw(9, 7, 1, 0), 2'(b));
      chk_cfg("R3 bad word");
    end

    // R9: off-edge commands do nothing
    skew_cmd(2'd1, mw(0, 6, 1, 1));
    chk_cfg("R9 mrs");
    skew_cmd(2'd2, 13'd0);
    idle(8);
    chk_cfg("R9 read");

    // R5 R6 R7: timing sweep over all legal settings
    for (int rm = 0; rm < 2; rm++)
      for (int bl = 1; bl <= 3; bl++)
        for (int c = 0; c < 2; c++)
          for (int il = 0; il < 2; il++) begin
            registered_mode = rm[0];
            cmd(1, 2'd1, mw(0, cls[c], il, bl), 2'd0);
            chk_cfg("R5");
            cmd(1, 2'd2, 13'd0, 2'd0);            // single read (R6)
            idle(8);
            for (int r = 0; r < 3; r++) begin     // back-to-back reads (R7)
              cmd(1, 2'd2, 13'd0, 2'd0);
              idle(m_len / 2 - 1);
            end
            idle(8);
            cmd(1, 2'd2, 13'd0, 2'd0);            // read, then a gapped read
            idle(m_len / 2);
            cmd(1, 2'd2, 13'd0, 2'd0);
            idle(12);
          end

    // R10: reset cancels a pending window
    registered_mode = 1;
    cmd(1, 2'd1, mw(0, 6, 0, 3), 2'd0);
    cmd(1, 2'd2, 13'd0, 2'd0);
    do_reset();
    idle(12);
    chk("R10 window cancelled", rd_valid, 0);
    chk("R1 cfg cleared", cfg_ok, 0);

    mon_on = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule